// File: doc/BRIEF.md
# Synchronous Phase Demodulator

This block recovers the slow phase pattern carried by a synchronization signal. It takes a stream of signed samples, one per clock, together with a one-bit square carrier produced by a separate carrier-recovery stage. The carrier bit is turned into a bipolar weight of plus or minus one. It is then held back a fixed number of samples so that it lines up with the sample stream. Each sample is multiplied by that weight, which is done as a conditional negation. The products are smoothed by a low-pass FIR filter, and the filter result is reduced to a single bit by a greater-than-zero decision.

When the incoming tone reverses phase, the smoothed product changes sign and the output bit toggles. Any two successive toggles of the output therefore bracket one period of the spreading code. A downstream circuit can use these toggles to restart its code generator. The sample width (default 20 bits, of which 17 are fraction bits), the carrier alignment delay, the tap count and the signed coefficient set are all parameters. The output stays low until the whole pipeline has been filled with samples taken after reset.

Top module: `phase_length_demod`

## Requirements
- R1: While reset is high, and directly after it is released, length_o is 0.
- R2: Carrier bit value 1 weights a sample by +1 and value 0 weights it by -1. The weight applied to the sample presented at clock edge n comes from the carrier bit presented at edge n-CAR_DLY (default 4). So the product is p[n] = x[n]*(2*c[n-CAR_DLY]-1).
- R3: The most negative input, -2^(IN_W-1), weighted by -1 gives +2^(IN_W-1) without overflow.
- R4: The filter result after edge m is the sum over i = 0..NTAPS-1 of h[i]*p[m-2-i]. Here h[i] is field i (bits i*COEF_W upward, signed) of COEFS.
- R5: After edge k, length_o is 1 exactly when the sum over i of h[i]*p[k-3-i] is strictly greater than zero. A sum of zero gives 0.
- R6: For the first FILL = CAR_DLY+NTAPS+2 edges after reset is released, length_o is held at 0 whatever the inputs are.
- R7: With a carrier-coherent input of constant magnitude and the default coefficients {1,2,3,4,4,3,2,1}, a phase reversal at sample f has these effects. Going from positive to negative, length_o falls after edge f+6. Going from negative to positive, it rises after edge f+7. No other toggles occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | IN_W | Signed input sample (two's complement) |
| carrier_i | input | 1 | Recovered unipolar square carrier |
| length_o | output | 1 | Demodulated phase bit; edges bound a code period |

## Verification
Several properties are checked on every cycle by the assertions. The mixer must keep the magnitude of the sample, and its sign must agree with the delayed carrier weight. The filter must return zero when its delay line holds only zeros. The output must stay low during the fill window and whenever the previous filter result is not positive. Other behaviours can only be shown by the bench scenarios. These are the exact carrier alignment delay, the filter latency, the cycle at which an edge appears after a phase reversal, the full-scale negation and the behaviour under misaligned carriers. The bench compares every output cycle against a convolution model built from the requirements.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

   // Accumulator width: product width plus coefficient width plus growth
   function automatic int acc_width(input int in_w, input int coef_w, input int ntaps);
      return in_w + 1 + coef_w + $clog2(ntaps + 1) + 1;
   endfunction

   // Number of edges during which the slicer output is forced low
   function automatic int fill_edges(input int car_dly, input int ntaps);
      return car_dly + ntaps + 2;
   endfunction

endpackage

// File: rtl/carrier_align.sv
module carrier_align #(
   parameter int CAR_DLY = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic car_i,
   output logic pos_o
);

   generate
      if (CAR_DLY < 0) begin : g_bad
         $error("carrier_align: CAR_DLY must be non-negative");
      end
      if (CAR_DLY == 0) begin : g_direct
         assign pos_o = car_i;
      end else begin : g_shift
         logic [CAR_DLY-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else if (CAR_DLY == 1) stage_q <= car_i;
            else stage_q <= {stage_q[CAR_DLY-2:0], car_i};
         end
         assign pos_o = stage_q[CAR_DLY-1];
      end
   endgenerate

endmodule

// File: rtl/sign_mixer.sv
module sign_mixer #(
   parameter int IN_W = 20
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic signed [IN_W-1:0] x_i,
   input  logic                   pos_i,
   output logic signed [IN_W:0]   p_o
);

   localparam int PW = IN_W + 1;

   generate
      if (IN_W < 2) begin : g_bad
         $error("sign_mixer: IN_W must be at least 2");
      end
   endgenerate

   logic signed [PW-1:0] x_ext;
   assign x_ext = PW'(x_i);

   always_ff @(posedge clk) begin
      if (rst) p_o <= '0;
      else     p_o <= pos_i ? x_ext : -x_ext;
   end

   logic signed [PW-1:0] p_abs, x_abs_past;
   assign p_abs = p_o[PW-1] ? -p_o : p_o;
   logic signed [PW-1:0] x_abs;
   assign x_abs = x_ext[PW-1] ? -x_ext : x_ext;
   always_ff @(posedge clk) x_abs_past <= x_abs;

   // R3: magnitude survives negation, including full scale
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (p_abs == x_abs_past) && !p_abs[PW-1]);

   // R2: sign of product follows the bipolar carrier weight
   a_r2_sign_follows: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x_i) > 0) |-> (p_o > 0) == $past(pos_i));

endmodule

// File: rtl/lpf_fir.sv
module lpf_fir #(
   parameter int                     PW     = 21,
   parameter int                     COEF_W = 8,
   parameter int                     NTAPS  = 8,
   parameter logic [NTAPS*COEF_W-1:0] COEFS = '0,
   parameter int                     AW     = 34
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [PW-1:0] p_i,
   output logic signed [AW-1:0] acc_o
);

   generate
      if (NTAPS < 1) begin : g_bad_taps
         $error("lpf_fir: NTAPS must be at least 1");
      end
      if (AW < PW + COEF_W) begin : g_bad_aw
         $error("lpf_fir: accumulator too narrow");
      end
   endgenerate

   logic signed [PW-1:0] z_q [NTAPS];

   generate
      for (genvar i = 0; i < NTAPS; i++) begin : g_tap
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst) z_q[0] <= '0;
               else     z_q[0] <= p_i;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst) z_q[i] <= '0;
               else     z_q[i] <= z_q[i-1];
            end
         end
      end
   endgenerate

   logic signed [AW-1:0] sum_c;
   always_comb begin
      sum_c = '0;
      for (int i = 0; i < NTAPS; i++) begin
         sum_c = sum_c + AW'(z_q[i]) * AW'($signed(COEFS[i*COEF_W +: COEF_W]));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) acc_o <= '0;
      else     acc_o <= sum_c;
   end

   logic all_zero;
   always_comb begin
      all_zero = 1'b1;
      for (int i = 0; i < NTAPS; i++) if (z_q[i] != '0) all_zero = 1'b0;
   end

   // R4: an empty delay line yields a zero filter result one edge later
   a_r4_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
      $past(all_zero) |-> acc_o == '0);

endmodule

// File: rtl/slicer_hold.sv
module slicer_hold #(
   parameter int AW   = 34,
   parameter int FILL = 14
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [AW-1:0] acc_i,
   output logic                 bit_o
);

   localparam int CW = $clog2(FILL + 1) + 1;

   generate
      if (FILL < 1) begin : g_bad
         $error("slicer_hold: FILL must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          filled;
   assign filled = (cnt_q >= CW'(FILL));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         bit_o <= 1'b0;
      end else begin
         if (!filled) cnt_q <= cnt_q + 1'b1;
         bit_o <= filled && (acc_i > 0);
      end
   end

   // R6: output stays low while the pipeline fills
   a_r6_quiet_fill: assert property (@(posedge clk) disable iff (rst)
      !filled |=> !bit_o);

   // R5: a non-positive filter result never produces a high output
   a_r5_nonpos_low: assert property (@(posedge clk) disable iff (rst)
      (acc_i <= 0) |=> !bit_o);

   // R6: the fill counter never runs backwards after reset
   a_r6_count_mono: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/phase_length_demod.sv
module phase_length_demod #(
   parameter int                     IN_W    = 20,
   parameter int                     COEF_W  = 8,
   parameter int                     NTAPS   = 8,
   parameter int                     CAR_DLY = 4,
   parameter logic [NTAPS*COEF_W-1:0] COEFS  =
      {8'sd1, 8'sd2, 8'sd3, 8'sd4, 8'sd4, 8'sd3, 8'sd2, 8'sd1}
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic signed [IN_W-1:0] sample_i,
   input  logic                   carrier_i,
   output logic                   length_o
);

   localparam int PW   = IN_W + 1;
   localparam int AW   = pdm_pkg::acc_width(IN_W, COEF_W, NTAPS);
   localparam int FILL = pdm_pkg::fill_edges(CAR_DLY, NTAPS);

   generate
      if (COEF_W < 2) begin : g_bad_coef
         $error("phase_length_demod: COEF_W must be at least 2");
      end
   endgenerate

   logic                 pos_w;
   logic signed [PW-1:0] prod_w;
   logic signed [AW-1:0] acc_w;

   carrier_align #(.CAR_DLY(CAR_DLY)) u_align (
      .clk(clk), .rst(rst), .car_i(carrier_i), .pos_o(pos_w));

   sign_mixer #(.IN_W(IN_W)) u_mix (
      .clk(clk), .rst(rst), .x_i(sample_i), .pos_i(pos_w), .p_o(prod_w));

   lpf_fir #(.PW(PW), .COEF_W(COEF_W), .NTAPS(NTAPS), .COEFS(COEFS), .AW(AW)) u_fir (
      .clk(clk), .rst(rst), .p_i(prod_w), .acc_o(acc_w));

   slicer_hold #(.AW(AW), .FILL(FILL)) u_slice (
      .clk(clk), .rst(rst), .acc_i(acc_w), .bit_o(length_o));

   // R1: output low on the first edge after reset release
   a_r1_reset_low: assert property (@(posedge clk) $past(rst) |-> !length_o);

   // R5: a rising output requires a positive filter result one edge before
   a_r5_rise_positive: assert property (@(posedge clk) disable iff (rst)
      $rose(length_o) |-> $past(acc_w) > 0);

endmodule

// File: tb/tb_phase_length_demod.sv
module tb_phase_length_demod;

   localparam int IN_W = 20, COEF_W = 8, NTAPS = 8, CAR_DLY = 4;
   localparam logic [NTAPS*COEF_W-1:0] H =
      {8'sd1, 8'sd2, 8'sd3, 8'sd4, 8'sd4, 8'sd3, 8'sd2, 8'sd1};
   localparam int FILL = CAR_DLY + NTAPS + 2;
   localparam int HMAX = 4096;

   logic clk = 1'b0, rst = 1'b1, car = 1'b0, lo;
   logic signed [IN_W-1:0] smp = '0;

   int total = 0, bad = 0, k = 0;
   longint xh [HMAX];
   bit     ch [HMAX];

   always #4 clk = ~clk;

   phase_length_demod #(.IN_W(IN_W), .COEF_W(COEF_W), .NTAPS(NTAPS),
      .CAR_DLY(CAR_DLY), .COEFS(H)) dut (
      .clk(clk), .rst(rst), .sample_i(smp), .carrier_i(car), .length_o(lo));

   function automatic longint pw(int j);
      if (j < 1 || j - CAR_DLY < 1) return 0;
      return xh[j] * (ch[j-CAR_DLY] ? 1 : -1);
   endfunction

   function automatic bit expect_out(int kk);
      longint s = 0;
      if (kk <= FILL) return 1'b0;
      for (int i = 0; i < NTAPS; i++)
         s += longint'($signed(H[i*COEF_W +: COEF_W])) * pw(kk - 3 - i);
      return s > 0;
   endfunction

   task automatic chk(bit cond, string req, longint act, longint exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; smp = '0; car = 1'b0;
      repeat (3) @(negedge clk);
      chk(lo == 1'b0, "R1 reset", lo, 0);
      rst = 1'b0; k = 0;
      for (int i = 0; i < HMAX; i++) begin xh[i] = 0; ch[i] = 0; end
   endtask

   // drive one sample, clock it, check output against the model
   task automatic step(longint x, bit c, string req);
      xh[k+1] = x; ch[k+1] = c;
      smp = IN_W'(x); car = c;
      @(posedge clk); k++;
      @(negedge clk);
      chk(lo == expect_out(k), req, lo, expect_out(k));
   endtask

   function automatic bit sqr(int n);
      return ((n / 10) % 2) == 1;
   endfunction

   task automatic t_flips();
      int last = 0, fall1 = -1, rise1 = -1, fall2 = -1, edges = 0;
      longint ph;
      do_reset();
      for (int n = 1; n <= 400; n++) begin
         ph = (n >= 100 && n < 200) || (n >= 300) ? -1 : 1;
         step(ph * 5000 * ((n > CAR_DLY && sqr(n - CAR_DLY)) ? 1 : -1), sqr(n), "R7 model");
         if (k == FILL + 1) last = lo;
         else if (k > FILL + 1 && lo != last) begin
            edges++;
            if (!lo && fall1 < 0) fall1 = k;
            else if (lo && rise1 < 0) rise1 = k;
            else if (!lo) fall2 = k;
            last = lo;
         end
      end
      chk(edges == 3, "R7 edge count", edges, 3);
      chk(fall1 == 106, "R7 fall after flip", fall1, 106);
      chk(rise1 == 207, "R7 rise after flip", rise1, 207);
      chk(fall2 == 306, "R7 second fall", fall2, 306);
   endtask

   task automatic t_fill_hold();
      do_reset();
      for (int n = 1; n <= FILL; n++) begin
         step(40000, 1'b1, "R6 fill");
         chk(lo == 1'b0, "R6 held low", lo, 0);
      end
      for (int n = 1; n <= 20; n++) step(40000, 1'b1, "R2 aligned positive");
      chk(lo == 1'b1, "R2 constant +1 weight", lo, 1);
   endtask

   task automatic t_fullscale();
      longint mn = -(longint'(1) << (IN_W - 1));
      do_reset();
      for (int n = 1; n <= 40; n++) step(mn, 1'b0, "R3 full-scale negate");
      chk(lo == 1'b1, "R3 full-scale sign", lo, 1);
      for (int n = 1; n <= 40; n++) step(mn, 1'b1, "R3 full-scale keep");
      chk(lo == 1'b0, "R3 full-scale negative", lo, 0);
   endtask

   task automatic t_zero();
      do_reset();
      for (int n = 1; n <= 60; n++) step(0, sqr(n), "R5 zero sum low");
      chk(lo == 1'b0, "R5 zero input", lo, 0);
   endtask

   task automatic t_varied();
      do_reset();
      for (int n = 1; n <= 300; n++)
         step(((n % 3 == 0) ? 800 : 3100) * ((n / 37) % 2 ? -1 : 1)
              * ((n > 2 && sqr(n - 2)) ? 1 : -1), sqr(n), "R4 misaligned/varied");
   endtask

   initial begin
      #(200000 * 8);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_fill_hold();
      t_flips();
      t_fullscale();
      t_zero();
      t_varied();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule